// File: doc/BRIEF.md
# Master Timestamp and Sync Generator

This block is the single timebase of a triggerless acquisition system in which every card stamps its data with a common time. It keeps a wide timestamp counter that advances once per master clock cycle. At 100 MHz one tick is 10 ns. The counter stays at zero after reset until a start is requested. A start request comes in asynchronously and is synchronised, then turned into one fast-start event. That event clears the counter and launches it, and it pulses a start strobe on every enabled distribution output in the same cycle.

While the counter runs, the block marks each boundary of a power-of-two block of ticks with a one-cycle SYNC strobe. The default block is 65536 ticks, or 655.36 us. Downstream cards use these strobes to check that their local copies of the time are still aligned. The block has a parameterised number of identical outputs, eight by default. Each output carries its own SYNC and start strobe, and a per-output enable can silence it.

Top module: `tsm_master`

## Requirements
- R1: During and after reset, `timestamp` reads 0 and every `sync_out` and `start_out` bit is 0. Until the first start event, `timestamp` holds at 0 and no strobe is raised.
- R2: Once started, `timestamp` increases by exactly one every clock cycle. After 2^TS_W - 1 it wraps silently to 0, and the wrap raises no start strobe.
- R3: While running, an enabled output raises `sync_out` for exactly one cycle in every cycle where the low SYNC_LOG2 bits of `timestamp` read 0. The start cycle is the one exception. Consecutive SYNC strobes are therefore 2^SYNC_LOG2 cycles apart, which is 65536 cycles by default.
- R4: A rising edge on `start_req` produces one start event. Take edge 1 as the first rising clock edge that samples `start_req` high. After edge 3, every enabled `start_out` bit is high for one cycle, and in that same cycle `timestamp` reads 0.
- R5: Holding `start_req` high produces no further start event. A new start needs `start_req` to be sampled low and then high again.
- R6: A start event while the counter is already running clears `timestamp` to 0 again, and counting resumes from there.
- R7: Bit i of `port_en` gates both strobes of output i, and the value sampled at the edge that produces a strobe is the one that applies. A disabled output stays low. `timestamp` does not depend on `port_en`.
- R8: If a start event falls in the cycle in which a SYNC boundary would otherwise be reached, the start takes priority. The outputs show the start strobe with `sync_out` low and `timestamp` at 0. The next SYNC follows 2^SYNC_LOG2 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one timestamp tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Asynchronous start request; its rising edge launches the count |
| port_en | input | N_OUT | Per-output enable for the SYNC and start strobes |
| timestamp | output | TS_W | Current tick count |
| sync_out | output | N_OUT | One-cycle SYNC strobe per output |
| start_out | output | N_OUT | One-cycle start strobe per output |

## Verification
The two functions that can meet in one cycle are a fresh start event and a SYNC boundary. Both want to act on the same edge: one clears the counter and the other announces that the low bits are about to roll over. The bench provokes the collision on a small instance with an 8-tick SYNC period. It watches the running count and raises `start_req` exactly three edges before the tick that would close the SYNC block. It then judges that cycle by three things: the start strobe on every enabled output, all SYNC strobes low, and a timestamp of zero. It also checks that the next SYNC comes one full period after the start.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  // Pair of strobes produced by one distribution output
  typedef struct packed {
    logic sync;
    logic start;
  } strobe_t;

endpackage

// File: rtl/tsm_start_sync.sv
module tsm_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic start_evt
);

  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], req};
      last_q <= sh_q[STAGES-1];
    end
  end

  // rising edge of the synchronised request
  assign start_evt = sh_q[STAGES-1] & ~last_q;

  // R5: a start event never lasts more than one cycle
  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !start_evt);

endmodule

// File: rtl/tsm_counter.sv
module tsm_counter #(
  parameter int TS_W      = 48,
  parameter int SYNC_LOG2 = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_evt,
  output logic [TS_W-1:0] count_q,
  output logic            wrap_evt
);

  logic running_q;

  function automatic logic at_last_tick(input logic [SYNC_LOG2-1:0] low);
    return &low;
  endfunction

  function automatic logic [TS_W-1:0] step(input logic [TS_W-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      running_q <= 1'b0;
    end else if (start_evt) begin
      count_q   <= '0;
      running_q <= 1'b1;
    end else if (running_q) begin
      count_q   <= step(count_q);
    end
  end

  // next edge closes a SYNC block, unless a start takes that edge
  assign wrap_evt = running_q & ~start_evt & at_last_tick(count_q[SYNC_LOG2-1:0]);

  // R1: idle counter stays at zero
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !start_evt) |=> count_q == '0);

  // R2: one tick per cycle while running
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !start_evt) |=> count_q == TS_W'($past(count_q) + 1'b1));

  // R3: a wrap event lands on a zero low field
  p_wrap_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> count_q[SYNC_LOG2-1:0] == '0);

  // R6: start clears and launches
  p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (count_q == '0) && running_q);

endmodule

// File: rtl/tsm_out_port.sv
module tsm_out_port (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_evt,
  input  logic             start_evt,
  output tsm_pkg::strobe_t strobe_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
    end else begin
      strobe_q.sync  <= en & sync_evt;
      strobe_q.start <= en & start_evt;
    end
  end

  // R7: a disabled output raises nothing on the following cycle
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!strobe_q.sync && !strobe_q.start));

endmodule

// File: rtl/tsm_master.sv
module tsm_master #(
  parameter int TS_W        = 48,
  parameter int SYNC_LOG2   = 16,
  parameter int N_OUT       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [N_OUT-1:0] port_en,
  output logic [TS_W-1:0]  timestamp,
  output logic [N_OUT-1:0] sync_out,
  output logic [N_OUT-1:0] start_out
);

  logic start_evt;
  logic wrap_evt;

  tsm_start_sync #(.STAGES(SYNC_STAGES)) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (start_req),
    .start_evt (start_evt)
  );

  tsm_counter #(.TS_W(TS_W), .SYNC_LOG2(SYNC_LOG2)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .count_q   (timestamp),
    .wrap_evt  (wrap_evt)
  );

  tsm_pkg::strobe_t strobe [N_OUT];

  for (genvar g = 0; g < N_OUT; g++) begin : g_port
    tsm_out_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (port_en[g]),
      .sync_evt  (wrap_evt),
      .start_evt (start_evt),
      .strobe_q  (strobe[g])
    );
    assign sync_out[g]  = strobe[g].sync;
    assign start_out[g] = strobe[g].start;
  end

  // R3: SYNC strobes only on a zero low field
  p_sync_lowbits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|sync_out) |-> timestamp[SYNC_LOG2-1:0] == '0);

  // R4: start strobes coincide with a zero timestamp
  p_start_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_out) |-> timestamp == '0);

  // R8: start and SYNC never share a cycle on any output
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out & start_out) == '0);

endmodule

// File: tb/test_tsm_master.sv
module test_tsm_master;

  localparam int SW = 6;
  localparam int SL = 3;
  localparam int SN = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  // big instance, default parameters
  logic        req_b;
  logic [7:0]  en_b;
  logic [47:0] ts_b;
  logic [7:0]  sync_b, start_b;

  // small instance for wrap, random and collision work
  logic          req_s;
  logic [SN-1:0] en_s;
  logic [SW-1:0] ts_s;
  logic [SN-1:0] sync_s, start_s;

  tsm_master i_tsm_master (
    .clk(clk), .rst_n(rst_n), .start_req(req_b), .port_en(en_b),
    .timestamp(ts_b), .sync_out(sync_b), .start_out(start_b));

  tsm_master #(.TS_W(SW), .SYNC_LOG2(SL), .N_OUT(SN)) i_tsm_master_small (
    .clk(clk), .rst_n(rst_n), .start_req(req_s), .port_en(en_s),
    .timestamp(ts_s), .sync_out(sync_s), .start_out(start_s));

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit on_boundary(input int unsigned v, input int unsigned log2);
    return (v % (32'd1 << log2)) == 0;
  endfunction

  // requirement-level model of the small instance
  bit          m_d1, m_d2, m_d3, m_run;
  int unsigned m_ts;
  logic [SN-1:0] m_sync, m_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_d1 = 0; m_d2 = 0; m_d3 = 0; m_run = 0; m_ts = 0;
      m_sync = '0; m_start = '0;
    end else begin
      bit ev, wrap;
      ev   = m_d2 && !m_d3;                    // R4 three-edge latency
      wrap = m_run && !ev && on_boundary((m_ts + 1) % (1 << SW), SL);
      m_sync  = wrap ? en_s : '0;
      m_start = ev   ? en_s : '0;
      if (ev) begin m_ts = 0; m_run = 1; end
      else if (m_run) m_ts = (m_ts + 1) % (1 << SW);
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = req_s;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      chk("R2", "small timestamp", ts_s, m_ts);
      chk("R3", "small sync_out", sync_s, m_sync);
      chk("R4", "small start_out", start_s, m_start);
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed_dummy;
    int gap, extra;
    rst_n = 0; req_b = 0; en_b = '0; req_s = 0; en_s = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset timestamp", ts_b, 0);
    chk("R1", "reset sync_out", sync_b, 0);
    chk("R1", "reset start_out", start_b, 0);
    chk("R1", "reset small timestamp", ts_s, 0);
    rst_n = 1;
    mon_on = 1;
    en_b = 8'hFF;
    repeat (20) @(negedge clk);
    chk("R1", "idle timestamp before start", ts_b, 0);
    chk("R1", "idle sync_out before start", sync_b, 0);

    // random phase on the small instance (model checks every cycle)
    seed_dummy = $urandom(32'd715);
    for (int i = 0; i < 400; i++) begin
      en_s = SN'($urandom);
      if ($urandom_range(0, 2) == 0) req_s = ~req_s;
      repeat ($urandom_range(1, 12)) @(negedge clk);
    end

    // guaranteed launch, then R8 collision
    req_s = 0; repeat (4) @(negedge clk);
    req_s = 1; repeat (4) @(negedge clk);
    req_s = 0; repeat (4) @(negedge clk);
    en_s = '1;
    while ((m_ts % (1 << SL)) != (1 << SL) - 3) @(negedge clk);
    req_s = 1;
    repeat (3) @(negedge clk);
    chk("R8", "collision start_out", start_s, 3'b111);
    chk("R8", "collision sync_out", sync_s, 0);
    chk("R8", "collision timestamp", ts_s, 0);
    repeat (1 << SL) @(negedge clk);
    chk("R8", "sync after collision", sync_s, 3'b111);
    chk("R8", "timestamp after collision", ts_s, 1 << SL);
    extra = 0;
    repeat (40) begin @(negedge clk); if (start_s != 0) extra++; end
    chk("R5", "small held request restarts", extra, 0);
    mon_on = 0;

    // big instance: launch with partial enables
    chk("R1", "big still idle", ts_b, 0);
    en_b = 8'hA5; req_b = 1;
    @(negedge clk); chk("R4", "start after edge 1", start_b, 0);
    @(negedge clk); chk("R4", "start after edge 2", start_b, 0);
    @(negedge clk);
    chk("R4", "start after edge 3", start_b, 8'hA5);
    chk("R4", "timestamp in start cycle", ts_b, 0);
    chk("R7", "sync in start cycle", sync_b, 0);
    @(negedge clk);
    chk("R2", "first tick", ts_b, 1);
    chk("R5", "start one cycle", start_b, 0);

    gap = 1; extra = 0;
    while (sync_b == 0 && gap < 70000) begin
      @(negedge clk); gap++;
      if (start_b != 0) extra++;
    end
    chk("R3", "first sync spacing", gap, 65536);
    chk("R7", "first sync enabled mask", sync_b, 8'hA5);
    chk("R3", "timestamp at first sync", ts_b, 65536);
    chk("R5", "big held request restarts", extra, 0);
    en_b = 8'h3C;
    @(negedge clk);
    chk("R3", "sync one cycle wide", sync_b, 0);
    gap = 1;
    while (sync_b == 0 && gap < 70000) begin @(negedge clk); gap++; end
    chk("R3", "second sync spacing", gap, 65536);
    chk("R7", "second sync enabled mask", sync_b, 8'h3C);
    chk("R3", "timestamp at second sync", ts_b, 131072);

    // R6 restart while running
    req_b = 0; repeat (4) @(negedge clk);
    en_b = 8'h81; req_b = 1;
    repeat (3) @(negedge clk);
    chk("R6", "restart start_out", start_b, 8'h81);
    chk("R6", "restart timestamp", ts_b, 0);
    en_b = 8'h00;
    repeat (5) @(negedge clk);
    chk("R6", "count after restart", ts_b, 5);
    chk("R7", "timestamp independent of enables", ts_b != 0, 1);
    summary();
  end

endmodule